// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level table held in memory. A request carries the virtual address and whether the access is a write. The walker first reads a directory entry and then a leaf entry through a simple 32-bit read port. It checks the valid bit at each level and the read or write grant on the leaf. It then returns one of three results: the physical address with the page flags, a page fault, or a bus error.

The virtual address splits into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit page offset (bits 11:0). Every entry is 4 bytes. The directory base is sampled from `base_i` when a request is accepted. Only one walk is in flight at a time. A new request is refused until the previous response has been taken. The walker has no translation cache.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to `base_i + 4 * va[31:22]`.
- R2: When the directory entry has bit 0 set, the second read goes to `{dir_entry[31:12], 12'h000} + 4 * va[21:12]`.
- R3: A directory entry with bit 0 clear ends the walk with `rsp_kind_o = 2'd1` (page fault) after exactly one memory read.
- R4: A leaf entry with bit 0 clear ends the walk with a page fault.
- R5: Leaf bit 1 grants reads and leaf bit 2 grants writes. An access without its grant is a page fault. Every page fault returns `rsp_pa_o = 0`, `rsp_flags_o = 0` and `rsp_attr_o = 0`, with `rsp_va_o` and `rsp_write_o` set to the request's address and type.
- R6: A successful walk returns `rsp_kind_o = 2'd0`, `rsp_pa_o = {leaf[31:12], va[11:0]}` and `rsp_flags_o = leaf[8:1]`.
- R7: When leaf bit 3 is set, `rsp_attr_ovr_o = 1` and `rsp_attr_o = leaf[8:4]`. The five attribute bits are, from bit 4 upward: write cache, write allocate, write buffer, read cache and read allocate. When leaf bit 3 is clear, both outputs are 0.
- R8: `mem_err_i` on either read ends the walk with `rsp_kind_o = 2'd2` (bus error). A bus error on the directory read issues no second read.
- R9: `req_ready_o` is 1 only while no walk is in flight and no response is pending. A response stays valid and unchanged until `rsp_ready_i` is 1.
- R10: `mem_req_o` and `mem_addr_o` are held steady until the memory port answers with `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Directory base address, word aligned |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can take a request |
| req_va_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 for a write access, 0 for a read |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rvalid_i | input | 1 | Memory answer valid (may come in the same cycle as the request) |
| mem_rdata_i | input | 32 | Entry read from memory |
| mem_err_i | input | 1 | Memory answer is an error |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_kind_o | output | 2 | 0 ok, 1 page fault, 2 bus error |
| rsp_pa_o | output | 32 | Physical address (0 unless ok) |
| rsp_flags_o | output | 8 | Leaf bits 8:1 (0 unless ok) |
| rsp_attr_ovr_o | output | 1 | Cache attribute override active |
| rsp_attr_o | output | 5 | Overriding cache attributes |
| rsp_va_o | output | 32 | Virtual address of the walk |
| rsp_write_o | output | 1 | Access type of the walk |

## Verification
The properties assume that `base_i` is word aligned. They also assume that the memory port raises `mem_rvalid_i` only while `mem_req_o` is high. The bench builds the memory as a combinational lookup gated by the live request, with a programmable number of wait cycles before the answer. Every table base the bench uses is a multiple of 4 KB. The bench offers new requests while a response is still pending, so the refusal rule is exercised under backpressure rather than assumed.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_PFAULT = 2'd1,
    RSP_BUSERR = 2'd2
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIR,
    ST_LEAF,
    ST_DONE
  } walk_st_e;

  // leaf entry bit positions
  localparam int VLD_BIT = 0;
  localparam int RD_BIT  = 1;
  localparam int WR_BIT  = 2;
  localparam int OVR_BIT = 3;
  localparam int ATTR_LO = 4;
  localparam int ATTR_HI = 8;
  localparam int FLAG_LO = 1;
  localparam int FLAG_HI = 8;
  localparam int FLAG_W  = FLAG_HI - FLAG_LO + 1;
  localparam int ATTR_W  = ATTR_HI - ATTR_LO + 1;
  localparam int ENT_SH  = 2;  // 4-byte entries
endpackage

// File: rtl/walk_addr.sv
module walk_addr
  import walk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [VA_W-1:0]       base_i,
  input  logic [VA_W-OFF_W-1:0] vpn_i,
  input  logic [VA_W-OFF_W-1:0] tbl_base_i,
  input  logic                  leaf_i,
  output logic [VA_W-1:0]       addr_o
);
  localparam int PFN_W = VA_W - OFF_W;

  logic [DIR_W-1:0] dir_idx;
  logic [TBL_W-1:0] tbl_idx;
  logic [VA_W-1:0]  dir_addr, leaf_addr;

  assign dir_idx = vpn_i[PFN_W-1 -: DIR_W];
  assign tbl_idx = vpn_i[TBL_W-1:0];

  assign dir_addr  = base_i + ({{(VA_W-DIR_W){1'b0}}, dir_idx} << ENT_SH);
  assign leaf_addr = {tbl_base_i, {OFF_W{1'b0}}}
                   + ({{(VA_W-TBL_W){1'b0}}, tbl_idx} << ENT_SH);
  assign addr_o    = leaf_i ? leaf_addr : dir_addr;
endmodule

// File: rtl/leaf_check.sv
module leaf_check
  import walk_pkg::*;
(
  input  logic [ATTR_HI:0]   entry_i,
  input  logic               write_i,
  output logic               grant_o,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               ovr_o,
  output logic [ATTR_W-1:0]  attr_o
);
  logic perm;

  assign perm    = write_i ? entry_i[WR_BIT] : entry_i[RD_BIT];
  assign grant_o = entry_i[VLD_BIT] & perm;
  assign flags_o = entry_i[FLAG_HI:FLAG_LO];
  assign ovr_o   = entry_i[OVR_BIT];

  // attributes only pass through when the override bit is set
  for (genvar g = 0; g < ATTR_W; g++) begin : g_attr
    assign attr_o[g] = entry_i[ATTR_LO+g] & entry_i[OVR_BIT];
  end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [VA_W-1:0]       req_va_i,
  input  logic                  req_write_i,
  input  logic [VA_W-1:0]       base_i,
  output logic                  req_ready_o,
  input  logic                  mem_rvalid_i,
  input  logic                  mem_err_i,
  input  logic                  ent_vld_i,
  input  logic [VA_W-OFF_W-1:0] ent_base_i,
  input  logic                  leaf_grant_i,
  input  logic [FLAG_W-1:0]     leaf_flags_i,
  input  logic                  leaf_ovr_i,
  input  logic [ATTR_W-1:0]     leaf_attr_i,
  output logic                  mem_req_o,
  output logic                  in_leaf_o,
  output logic [VA_W-1:0]       base_o,
  output logic [VA_W-OFF_W-1:0] tbl_base_o,
  input  logic                  rsp_ready_i,
  output logic                  rsp_valid_o,
  output logic [1:0]            rsp_kind_o,
  output logic [VA_W-1:0]       rsp_pa_o,
  output logic [FLAG_W-1:0]     rsp_flags_o,
  output logic                  rsp_attr_ovr_o,
  output logic [ATTR_W-1:0]     rsp_attr_o,
  output logic [VA_W-1:0]       rsp_va_o,
  output logic                  rsp_write_o
);
  localparam int PFN_W = VA_W - OFF_W;

  walk_st_e         st_q;
  rsp_kind_e        kind_q;
  logic [VA_W-1:0]  va_q, base_q, pa_q;
  logic             wr_q, ovr_q;
  logic [PFN_W-1:0] tbl_q;
  logic [FLAG_W-1:0] flags_q;
  logic [ATTR_W-1:0] attr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      kind_q  <= RSP_OK;
      va_q    <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      wr_q    <= 1'b0;
      ovr_q   <= 1'b0;
      tbl_q   <= '0;
      flags_q <= '0;
      attr_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          wr_q    <= req_write_i;
          base_q  <= base_i;
          kind_q  <= RSP_OK;
          pa_q    <= '0;
          flags_q <= '0;
          ovr_q   <= 1'b0;
          attr_q  <= '0;
          st_q    <= ST_DIR;
        end
        ST_DIR: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            kind_q <= RSP_BUSERR;
            st_q   <= ST_DONE;
          end else if (!ent_vld_i) begin
            kind_q <= RSP_PFAULT;
            st_q   <= ST_DONE;
          end else begin
            tbl_q <= ent_base_i;
            st_q  <= ST_LEAF;
          end
        end
        ST_LEAF: if (mem_rvalid_i) begin
          st_q <= ST_DONE;
          if (mem_err_i) begin
            kind_q <= RSP_BUSERR;
          end else if (!leaf_grant_i) begin
            kind_q <= RSP_PFAULT;
          end else begin
            kind_q  <= RSP_OK;
            pa_q    <= {ent_base_i, va_q[OFF_W-1:0]};
            flags_q <= leaf_flags_i;
            ovr_q   <= leaf_ovr_i;
            attr_q  <= leaf_attr_i;
          end
        end
        ST_DONE: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (st_q == ST_IDLE);
  assign mem_req_o      = (st_q == ST_DIR) || (st_q == ST_LEAF);
  assign in_leaf_o      = (st_q == ST_LEAF);
  assign base_o         = base_q;
  assign tbl_base_o     = tbl_q;
  assign rsp_valid_o    = (st_q == ST_DONE);
  assign rsp_kind_o     = kind_q;
  assign rsp_pa_o       = pa_q;
  assign rsp_flags_o    = flags_q;
  assign rsp_attr_ovr_o = ovr_q;
  assign rsp_attr_o     = attr_q;
  assign rsp_va_o       = va_q;
  assign rsp_write_o    = wr_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic              req_write_i,
  output logic              mem_req_o,
  output logic [VA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [VA_W-1:0]   mem_rdata_i,
  input  logic              mem_err_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [1:0]        rsp_kind_o,
  output logic [VA_W-1:0]   rsp_pa_o,
  output logic [FLAG_W-1:0] rsp_flags_o,
  output logic              rsp_attr_ovr_o,
  output logic [ATTR_W-1:0] rsp_attr_o,
  output logic [VA_W-1:0]   rsp_va_o,
  output logic              rsp_write_o
);
  localparam int PFN_W = VA_W - OFF_W;

  logic              in_leaf, grant, l_ovr;
  logic [VA_W-1:0]   base_q;
  logic [PFN_W-1:0]  tbl_base;
  logic [FLAG_W-1:0] l_flags;
  logic [ATTR_W-1:0] l_attr;

  walk_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_va_i       (req_va_i),
    .req_write_i    (req_write_i),
    .base_i         (base_i),
    .req_ready_o    (req_ready_o),
    .mem_rvalid_i   (mem_rvalid_i),
    .mem_err_i      (mem_err_i),
    .ent_vld_i      (mem_rdata_i[VLD_BIT]),
    .ent_base_i     (mem_rdata_i[VA_W-1:OFF_W]),
    .leaf_grant_i   (grant),
    .leaf_flags_i   (l_flags),
    .leaf_ovr_i     (l_ovr),
    .leaf_attr_i    (l_attr),
    .mem_req_o      (mem_req_o),
    .in_leaf_o      (in_leaf),
    .base_o         (base_q),
    .tbl_base_o     (tbl_base),
    .rsp_ready_i    (rsp_ready_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_kind_o     (rsp_kind_o),
    .rsp_pa_o       (rsp_pa_o),
    .rsp_flags_o    (rsp_flags_o),
    .rsp_attr_ovr_o (rsp_attr_ovr_o),
    .rsp_attr_o     (rsp_attr_o),
    .rsp_va_o       (rsp_va_o),
    .rsp_write_o    (rsp_write_o)
  );

  walk_addr #(.VA_W(VA_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)) u_addr (
    .base_i     (base_q),
    .vpn_i      (rsp_va_o[VA_W-1:OFF_W]),
    .tbl_base_i (tbl_base),
    .leaf_i     (in_leaf),
    .addr_o     (mem_addr_o)
  );

  leaf_check u_leaf (
    .entry_i (mem_rdata_i[ATTR_HI:0]),
    .write_i (rsp_write_o),
    .grant_o (grant),
    .flags_o (l_flags),
    .ovr_o   (l_ovr),
    .attr_o  (l_attr)
  );
endmodule

// File: rtl/walk_checks.sv
module walk_checks (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [1:0]  rsp_kind_o,
  input logic [31:0] rsp_pa_o,
  input logic [7:0]  rsp_flags_o,
  input logic        rsp_attr_ovr_o,
  input logic [4:0]  rsp_attr_o,
  input logic [31:0] rsp_va_o
);
  assert_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_fault_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o != 2'd0) |-> (rsp_pa_o == 32'h0 && rsp_flags_o == 8'h0));

  assert_offset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd0) |-> rsp_pa_o[11:0] == rsp_va_o[11:0]);

  assert_attr_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_attr_ovr_o) |-> rsp_attr_o == 5'h0);

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_o) |-> !req_ready_o);

  assert_rsp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_kind_o) && $stable(rsp_pa_o) && $stable(rsp_va_o)));

  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_kind_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_kind_o != 2'd3);
endmodule

bind pt_walker walk_checks u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_ready_o    (req_ready_o),
  .mem_req_o      (mem_req_o),
  .mem_addr_o     (mem_addr_o),
  .mem_rvalid_i   (mem_rvalid_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_ready_i    (rsp_ready_i),
  .rsp_kind_o     (rsp_kind_o),
  .rsp_pa_o       (rsp_pa_o),
  .rsp_flags_o    (rsp_flags_o),
  .rsp_attr_ovr_o (rsp_attr_ovr_o),
  .rsp_attr_o     (rsp_attr_o),
  .rsp_va_o       (rsp_va_o)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base = 32'h0010_0000;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, mem_req, mem_rvalid, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic        rsp_valid, rsp_ovr, rsp_write;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_pa, rsp_va;
  logic [7:0]  rsp_flags;
  logic [4:0]  rsp_attr;

  int n_run = 0, n_fail = 0;
  int stall_cycles = 0;
  int wait_cnt = 0;
  int reads = 0;

  always #10 clk = ~clk;  // 50 MHz

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_write_i(req_write),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_kind_o(rsp_kind),
    .rsp_pa_o(rsp_pa), .rsp_flags_o(rsp_flags), .rsp_attr_ovr_o(rsp_ovr),
    .rsp_attr_o(rsp_attr), .rsp_va_o(rsp_va), .rsp_write_o(rsp_write)
  );

  // sparse memory image: directory at 0x0010_0000
  localparam int NM = 12;
  localparam logic [31:0] M_ADDR [NM] = '{
    32'h0010_0004, 32'h0010_0008, 32'h0010_000C, 32'h0010_0FFC,
    32'h0020_0000, 32'h0020_0004, 32'h0020_0008, 32'h0020_000C,
    32'h0020_0010, 32'h0020_0014, 32'h0020_0018, 32'h0040_0FFC};
  localparam logic [31:0] M_DATA [NM] = '{
    32'h0020_0001, 32'h0030_0000, 32'h0000_0000, 32'h0040_0001,
    32'hABCD_E007, 32'h1234_5003, 32'h1111_1005, 32'h2222_2006,
    32'h0000_0000, 32'h3333_31AB, 32'h4444_41F3, 32'hFFFF_F003};
  localparam logic [NM-1:0] M_ERR = 12'b0001_0000_0100;  // index 2 and 8

  assign mem_rvalid = mem_req && (wait_cnt >= stall_cycles);

  always_comb begin
    mem_rdata = 32'h0;
    mem_err   = 1'b0;
    for (int k = 0; k < NM; k++) begin
      if (mem_addr == M_ADDR[k]) begin
        mem_rdata = M_DATA[k];
        mem_err   = M_ERR[k];
      end
    end
  end

  always @(posedge clk) begin
    if (mem_req && !mem_rvalid) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (mem_req && mem_rvalid) reads <= reads + 1;
  end

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [1:0]  kind;
    logic [31:0] pa;
    logic [7:0]  flags;
    logic        ovr;
    logic [4:0]  attr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    {32'h0040_0123, 1'b0, 2'd0, 32'hABCD_E123, 8'h03, 1'b0, 5'h00},  // R6 read
    {32'h0040_0FFF, 1'b1, 2'd0, 32'hABCD_EFFF, 8'h03, 1'b0, 5'h00},  // R6 write, top offset
    {32'h0040_1010, 1'b0, 2'd0, 32'h1234_5010, 8'h01, 1'b0, 5'h00},  // R5 read granted
    {32'h0040_1010, 1'b1, 2'd1, 32'h0,         8'h00, 1'b0, 5'h00},  // R5 write denied
    {32'h0040_2004, 1'b0, 2'd1, 32'h0,         8'h00, 1'b0, 5'h00},  // R5 read denied
    {32'h0040_2004, 1'b1, 2'd0, 32'h1111_1004, 8'h02, 1'b0, 5'h00},  // R5 write granted
    {32'h0040_3000, 1'b0, 2'd1, 32'h0,         8'h00, 1'b0, 5'h00},  // R4 invalid leaf
    {32'h0080_0000, 1'b1, 2'd1, 32'h0,         8'h00, 1'b0, 5'h00},  // R3 invalid directory
    {32'h00C0_0000, 1'b0, 2'd2, 32'h0,         8'h00, 1'b0, 5'h00},  // R8 directory error
    {32'h0040_4000, 1'b0, 2'd2, 32'h0,         8'h00, 1'b0, 5'h00},  // R8 leaf error
    {32'h0040_5ABC, 1'b0, 2'd0, 32'h3333_3ABC, 8'hD5, 1'b1, 5'h1A},  // R7 override
    {32'h0040_6000, 1'b0, 2'd0, 32'h4444_4000, 8'hF9, 1'b0, 5'h00},  // R7 no override
    {32'hFFFF_FFFF, 1'b0, 2'd0, 32'hFFFF_FFFF, 8'h01, 1'b0, 5'h00}   // R1 last directory slot
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] va, input logic wr);
    @(negedge clk);
    for (int g = 0; g < 100 && !req_ready; g++) @(negedge clk);
    req_va    = va;
    req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    for (int g = 0; g < 100 && !rsp_valid; g++) @(negedge clk);
  endtask

  task automatic take();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic string tag_of(input logic [1:0] k);
    return (k == 2'd0) ? "R6" : (k == 2'd1) ? "R5" : "R8";
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R9 reset ready", 32'(req_ready), 32'd1);
    chk("R9 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 reset mem_req", 32'(mem_req), 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      stall_cycles = i % 3;
      issue(VECS[i].va, VECS[i].wr);
      wait_rsp();
      chk({tag_of(VECS[i].kind), " kind"}, 32'(rsp_kind), 32'(VECS[i].kind));
      chk({tag_of(VECS[i].kind), " pa"}, rsp_pa, VECS[i].pa);
      chk({tag_of(VECS[i].kind), " flags"}, 32'(rsp_flags), 32'(VECS[i].flags));
      chk("R7 ovr", 32'(rsp_ovr), 32'(VECS[i].ovr));
      chk("R7 attr", 32'(rsp_attr), 32'(VECS[i].attr));
      chk("R5 va", rsp_va, VECS[i].va);
      chk("R5 write flag", 32'(rsp_write), 32'(VECS[i].wr));
      take();
    end

    // R1 / R2 / R10: addresses and hold under wait states
    stall_cycles = 3;
    issue(32'h0040_5ABC, 1'b0);
    chk("R1 dir addr", mem_addr, 32'h0010_0004);
    chk("R10 req up", 32'(mem_req), 32'd1);
    @(negedge clk);
    chk("R10 addr held", mem_addr, 32'h0010_0004);
    chk("R10 no rsp yet", 32'(rsp_valid), 32'd0);
    for (int g = 0; g < 20 && mem_addr == 32'h0010_0004; g++) @(negedge clk);
    chk("R2 leaf addr", mem_addr, 32'h0020_0014);
    wait_rsp();
    chk("R6 pa after stall", rsp_pa, 32'h3333_3ABC);

    // R9: backpressure with a second request pending
    req_va    = 32'h0040_0123;
    req_write = 1'b0;
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 refuse while pending", 32'(req_ready), 32'd0);
    chk("R9 no new read", 32'(mem_req), 32'd0);
    chk("R9 rsp held", rsp_pa, 32'h3333_3ABC);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    @(negedge clk);  // accepted at the posedge in between
    req_valid = 1'b0;
    wait_rsp();
    chk("R9 queued walk pa", rsp_pa, 32'hABCD_E123);
    take();

    // R3 / R4 / R8: number of reads per walk
    stall_cycles = 0;
    r0 = reads;
    issue(32'h0080_0000, 1'b0);
    wait_rsp();
    chk("R3 one read", 32'(reads - r0), 32'd1);
    chk("R3 fault", 32'(rsp_kind), 32'd1);
    take();
    r0 = reads;
    issue(32'h0040_3000, 1'b1);
    wait_rsp();
    chk("R4 two reads", 32'(reads - r0), 32'd2);
    chk("R4 fault write flag", 32'(rsp_write), 32'd1);
    take();
    r0 = reads;
    issue(32'h00C0_0000, 1'b0);
    wait_rsp();
    chk("R8 one read", 32'(reads - r0), 32'd1);
    chk("R8 kind", 32'(rsp_kind), 32'd2);
    take();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule